// File: doc/BRIEF.md
# Three-Tier Interrupt Status Encoder

This block collects interrupt requests from a critical tier (four inputs, never masked), a main tier (sixteen inputs, each with a disable bit) and a peripheral tier (thirty-two sources, each with a disable bit). Every cycle it finds the lowest-numbered live request in each tier and packs all three winners into one status word. Software reads that word and tests the critical flag first, then the main flag, then the peripheral flag.

Peripheral source 0 is not a pin. It is the summary of a secondary 32-bit DMA pending register. Pulses on `dma_set` set bits in that register, and software clears them by writing ones. The source reads high while any pending bit is also enabled in the DMA disable register. One peripheral source can be chosen by a configuration register and promoted into the critical tier or the main tier. There it occupies a reserved code that tells software "a peripheral won". When that happens, the peripheral field names the promoted source.

The block contains no state machine. Its only state is the register file: two tier disable masks, the promotion setting, and the DMA pending and DMA disable registers. All writes go through a simple synchronous register port. Reads are combinational, so the status word follows the request inputs in the same cycle.

Top module: `irq_tree_encoder`

## Requirements
- R1: In the first cycle after reset these values read back: main disable 0x00010FFF, peripheral disable 0x7FFFFC00, DMA disable 0xFFFFFFFF, DMA pending 0, promotion 0.
- R2: Status layout. Bit 10 is the critical valid flag and bits 9:8 are the critical code. Bit 21 is the main valid flag and bits 20:16 are the main code. Bit 29 is the peripheral valid flag and bits 28:24 are the peripheral code. All other bits are 0. In each tier the lowest-numbered live source wins. The word follows the inputs combinationally, in the same cycle.
- R3: Critical inputs cannot be masked. Input `crit_req[2]` has no effect, because code 2 is reserved for a promoted peripheral.
- R4: Main source n is disabled when bit (15-n) of the main disable register is 1. Input `main_req[4]` has no effect, because code 4 is reserved for a promoted peripheral.
- R5: Peripheral source n is disabled when bit (31-n) of the peripheral disable register is 1. Sources 1..31 come from `per_req[31:1]`.
- R6: The promotion register holds the source number in bits 4:0 and the mode in bits 9:8. Mode 1 sends the source to the critical tier as code 2. Mode 2 sends it to the main tier as code 4. Modes 0 and 3 turn promotion off. While promotion is on, the chosen source is left out of ordinary peripheral arbitration. If it is live, the peripheral field shows its number with the valid flag set.
- R7: `dma_set` bits set DMA pending bits. Writing to the DMA pending address clears every bit written as 1. When a set and a clear hit the same bit in the same cycle, the set wins.
- R8: Peripheral source 0 is live when any bit of (DMA pending AND NOT DMA disable) is 1 and disable bit 31 is 0.
- R9: Register addresses are: 0 status (read-only; writes are ignored), 1 main disable, 2 peripheral disable, 3 promotion (reads {22'b0, mode, 3'b0, source}), 4 DMA pending, 5 DMA disable. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crit_req | input | 4 | Critical tier requests |
| main_req | input | 16 | Main tier requests |
| per_req | input | 31 | Peripheral requests for sources 1..31 |
| dma_set | input | 32 | Pulses that set DMA pending bits |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |

## Verification
Two functions can land on the same DMA pending bit in the same cycle: a hardware set arriving on `dma_set` and a software write-one-to-clear. The bench provokes this by driving the same bit on `dma_set` and in the clear write within a single clock. It expects the bit to read back as 1. A second case clears one bit while setting a different one, and expects only the newly set bit to remain. A promoted peripheral and a genuine critical request are also raised together, to confirm that the lower critical code wins while the peripheral field still names the promoted source.

// File: rtl/itree_pkg.sv
package itree_pkg;
    localparam int DW     = 32;
    localparam int AW     = 3;
    localparam int CRIT_N = 4;
    localparam int MAIN_N = 16;
    localparam int PER_N  = 32;
    localparam int DMA_N  = 32;
    localparam int CODE_W = 5;

    localparam int CRIT_ALIAS = 2;
    localparam int MAIN_ALIAS = 4;

    localparam logic [AW-1:0] A_STAT  = 3'd0;
    localparam logic [AW-1:0] A_MMASK = 3'd1;
    localparam logic [AW-1:0] A_PMASK = 3'd2;
    localparam logic [AW-1:0] A_PROMO = 3'd3;
    localparam logic [AW-1:0] A_DPEND = 3'd4;
    localparam logic [AW-1:0] A_DMASK = 3'd5;

    localparam logic [DW-1:0] MMASK_RST = 32'h0001_0FFF;
    localparam logic [DW-1:0] PMASK_RST = 32'h7FFF_FC00;
    localparam logic [DW-1:0] DMASK_RST = 32'hFFFF_FFFF;

    localparam int CV_BIT = 10;
    localparam int CC_LSB = 8;
    localparam int MV_BIT = 21;
    localparam int MC_LSB = 16;
    localparam int PV_BIT = 29;
    localparam int PC_LSB = 24;

    typedef enum logic [1:0] {
        PROMO_OFF  = 2'd0,
        PROMO_CRIT = 2'd1,
        PROMO_MAIN = 2'd2,
        PROMO_RSVD = 2'd3
    } promo_mode_e;
endpackage

// File: rtl/itree_prio.sv
module itree_prio #(
    parameter int W  = 8,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/itree_regs.sv
module itree_regs
    import itree_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DMA_N-1:0]  dma_set,
    output logic [DW-1:0]     main_mask,
    output logic [DW-1:0]     per_mask,
    output logic [4:0]        promo_src,
    output promo_mode_e       promo_mode,
    output logic [DMA_N-1:0]  dma_pend,
    output logic [DMA_N-1:0]  dma_mask
);
    logic [DMA_N-1:0] clr_bits;

    always_comb begin
        clr_bits = '0;
        if (wr_en && addr == A_DPEND) clr_bits = wdata[DMA_N-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            main_mask  <= MMASK_RST;
            per_mask   <= PMASK_RST;
            dma_mask   <= DMASK_RST[DMA_N-1:0];
            dma_pend   <= '0;
            promo_src  <= '0;
            promo_mode <= PROMO_OFF;
        end else begin
            dma_pend <= (dma_pend & ~clr_bits) | dma_set;
            if (wr_en) begin
                case (addr)
                    A_MMASK: main_mask <= wdata;
                    A_PMASK: per_mask  <= wdata;
                    A_DMASK: dma_mask  <= wdata[DMA_N-1:0];
                    A_PROMO: begin
                        promo_src  <= wdata[4:0];
                        promo_mode <= promo_mode_e'(wdata[9:8]);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1
    reset_vals_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (main_mask == MMASK_RST && per_mask == PMASK_RST &&
                        dma_pend == '0 && promo_mode == PROMO_OFF));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DPEND && dma_set == '0)
            |=> ((dma_pend & $past(wdata[DMA_N-1:0])) == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_set != '0) |=> ((dma_pend & $past(dma_set)) == $past(dma_set)));
endmodule

// File: rtl/irq_tree_encoder.sv
module irq_tree_encoder
    import itree_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CRIT_N-1:0]  crit_req,
    input  logic [MAIN_N-1:0]  main_req,
    input  logic [PER_N-1:1]   per_req,
    input  logic [DMA_N-1:0]   dma_set,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata
);
    localparam int CIW = $clog2(CRIT_N);
    localparam int MIW = $clog2(MAIN_N);
    localparam int PIW = $clog2(PER_N);

    logic [DW-1:0]    main_mask, per_mask;
    logic [4:0]       promo_src;
    promo_mode_e      promo_mode;
    logic [DMA_N-1:0] dma_pend, dma_mask;

    itree_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .dma_set(dma_set), .main_mask(main_mask), .per_mask(per_mask),
        .promo_src(promo_src), .promo_mode(promo_mode),
        .dma_pend(dma_pend), .dma_mask(dma_mask)
    );

    // peripheral tier: source 0 is the DMA summary
    logic             dma_any;
    logic [PER_N-1:0] per_raw, per_live, per_ord, promo_sel;
    logic             promo_on, promo_hit;

    assign dma_any  = |(dma_pend & ~dma_mask);
    assign per_raw  = {per_req, dma_any};
    assign promo_on = (promo_mode == PROMO_CRIT) || (promo_mode == PROMO_MAIN);
    assign promo_sel = promo_on ? ({{(PER_N-1){1'b0}}, 1'b1} << promo_src) : '0;

    for (genvar n = 0; n < PER_N; n++) begin : g_per
        assign per_live[n] = per_raw[n] & ~per_mask[PER_N-1-n];
    end

    assign promo_hit = promo_on & per_live[promo_src];
    assign per_ord   = per_live & ~promo_sel;

    // critical tier, slot CRIT_ALIAS carries the promoted peripheral
    logic [CRIT_N-1:0] crit_vec;
    for (genvar i = 0; i < CRIT_N; i++) begin : g_crit
        if (i == CRIT_ALIAS) begin : g_alias
            assign crit_vec[i] = promo_hit && (promo_mode == PROMO_CRIT);
        end else begin : g_pin
            assign crit_vec[i] = crit_req[i];
        end
    end

    // main tier, slot MAIN_ALIAS carries the promoted peripheral
    logic [MAIN_N-1:0] main_vec;
    for (genvar n = 0; n < MAIN_N; n++) begin : g_main
        if (n == MAIN_ALIAS) begin : g_alias
            assign main_vec[n] = promo_hit && (promo_mode == PROMO_MAIN);
        end else begin : g_pin
            assign main_vec[n] = main_req[n] & ~main_mask[MAIN_N-1-n];
        end
    end

    logic           crit_v, main_v, ord_v;
    logic [CIW-1:0] crit_idx;
    logic [MIW-1:0] main_idx;
    logic [PIW-1:0] ord_idx;

    itree_prio #(.W(CRIT_N)) u_crit (.req(crit_vec), .valid(crit_v), .idx(crit_idx));
    itree_prio #(.W(MAIN_N)) u_main (.req(main_vec), .valid(main_v), .idx(main_idx));
    itree_prio #(.W(PER_N))  u_per  (.req(per_ord),  .valid(ord_v),  .idx(ord_idx));

    logic              per_v;
    logic [CODE_W-1:0] per_code;
    assign per_v    = promo_hit | ord_v;
    assign per_code = promo_hit ? promo_src : CODE_W'(ord_idx);

    logic [DW-1:0] status;
    always_comb begin
        status = '0;
        status[CV_BIT]                = crit_v;
        status[CC_LSB +: CIW]         = crit_idx;
        status[MV_BIT]                = main_v;
        status[MC_LSB +: CODE_W]      = CODE_W'(main_idx);
        status[PV_BIT]                = per_v;
        status[PC_LSB +: CODE_W]      = per_code;
    end

    always_comb begin
        case (addr)
            A_STAT:  rdata = status;
            A_MMASK: rdata = main_mask;
            A_PMASK: rdata = per_mask;
            A_PROMO: rdata = {22'b0, promo_mode, 3'b0, promo_src};
            A_DPEND: rdata = DW'(dma_pend);
            A_DMASK: rdata = DW'(dma_mask);
            default: rdata = '0;
        endcase
    end

    // R2
    crit_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        crit_v |-> (crit_vec[crit_idx] &&
                    (crit_vec & ((CRIT_N'(1) << crit_idx) - CRIT_N'(1))) == '0));

    // R2
    main_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        main_v |-> (main_vec[main_idx] &&
                    (main_vec & ((MAIN_N'(1) << main_idx) - MAIN_N'(1))) == '0));

    // R6
    crit_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (status[CV_BIT] && status[CC_LSB +: CIW] == CIW'(CRIT_ALIAS))
            |-> (status[PV_BIT] && status[PC_LSB +: CODE_W] == promo_src));

    // R6
    main_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (status[MV_BIT] && status[MC_LSB +: CODE_W] == CODE_W'(MAIN_ALIAS))
            |-> (status[PV_BIT] && status[PC_LSB +: CODE_W] == promo_src));
endmodule

// File: tb/irq_tree_encoder_test.sv
module irq_tree_encoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  crit_req = '0;
    logic [15:0] main_req = '0;
    logic [31:1] per_req  = '0;
    logic [31:0] dma_set  = '0;
    logic        wr_en    = 1'b0;
    logic [2:0]  addr     = '0;
    logic [31:0] wdata    = '0;
    logic [31:0] rdata;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_tree_encoder uut (
        .clk(clk), .rst(rst), .crit_req(crit_req), .main_req(main_req),
        .per_req(per_req), .dma_set(dma_set), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [31:0] st(bit cv, int cc, bit mv, int mc, bit pv, int pc);
        return {2'b0, pv, pc[4:0], 2'b0, mv, mc[4:0], 5'b0, cv, cc[1:0], 8'b0};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd0; wdata = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
        addr = 3'd0;
    endtask

    task automatic pulse_dma(logic [31:0] v);
        @(negedge clk);
        dma_set = v;
        @(negedge clk);
        dma_set = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        rd(3'd1, v); chk("R1 main disable", v, 32'h0001_0FFF);
        rd(3'd2, v); chk("R1 per disable", v, 32'h7FFF_FC00);
        rd(3'd5, v); chk("R1 dma disable", v, 32'hFFFF_FFFF);
        rd(3'd4, v); chk("R1 dma pending", v, 32'h0);
        rd(3'd3, v); chk("R1 promotion", v, 32'h0);
        rd(3'd0, v); chk("R2 idle status", v, 32'h0);
    endtask

    task automatic t_crit;
        logic [31:0] v;
        @(negedge clk); crit_req = 4'b1010;
        rd(3'd0, v); chk("R2 crit lowest", v, st(1, 1, 0, 0, 0, 0));
        crit_req = 4'b0100;
        rd(3'd0, v); chk("R3 crit input 2 ignored", v, st(0, 0, 0, 0, 0, 0));
        crit_req = 4'b1100;
        rd(3'd0, v); chk("R3 crit code 3", v, st(1, 3, 0, 0, 0, 0));
        crit_req = 4'b0;
    endtask

    task automatic t_main;
        logic [31:0] v;
        @(negedge clk); main_req = 16'h0FE0;
        rd(3'd0, v); chk("R4 main masked at reset", v, st(0, 0, 0, 0, 0, 0));
        main_req = 16'h0FE2;
        rd(3'd0, v); chk("R4 main source 1 enabled", v, st(0, 0, 1, 1, 0, 0));
        main_req = 16'h0;
        wr(3'd1, 32'h0);
        main_req = 16'h0030;
        rd(3'd0, v); chk("R4 main input 4 ignored", v, st(0, 0, 1, 5, 0, 0));
        main_req = 16'h8000;
        wr(3'd1, 32'h1);
        rd(3'd0, v); chk("R4 main src15 bit0", v, st(0, 0, 0, 0, 0, 0));
        wr(3'd1, 32'h0);
        rd(3'd0, v); chk("R4 main src15 live", v, st(0, 0, 1, 15, 0, 0));
        main_req = 16'h0;
    endtask

    task automatic t_per;
        logic [31:0] v;
        @(negedge clk); per_req[5] = 1'b1;
        rd(3'd0, v); chk("R5 per 5 masked at reset", v, st(0, 0, 0, 0, 0, 0));
        per_req[25] = 1'b1;
        rd(3'd0, v); chk("R5 per 25 enabled at reset", v, st(0, 0, 0, 0, 1, 25));
        per_req = '0;
        wr(3'd2, 32'h0);
        per_req[7] = 1'b1; per_req[20] = 1'b1;
        rd(3'd0, v); chk("R5 per lowest", v, st(0, 0, 0, 0, 1, 7));
        wr(3'd2, 32'h0100_0000);
        rd(3'd0, v); chk("R5 per 7 disabled", v, st(0, 0, 0, 0, 1, 20));
        wr(3'd2, 32'h0100_0800);
        rd(3'd0, v); chk("R5 per 20 disabled", v, st(0, 0, 0, 0, 0, 0));
        per_req = '0;
        wr(3'd2, 32'h0);
    endtask

    task automatic t_dma;
        logic [31:0] v;
        pulse_dma(32'h20);
        rd(3'd4, v); chk("R7 dma set", v, 32'h20);
        rd(3'd0, v); chk("R8 dma disabled", v, st(0, 0, 0, 0, 0, 0));
        wr(3'd5, 32'hFFFF_FFDF);
        rd(3'd0, v); chk("R8 cascade source 0", v, st(0, 0, 0, 0, 1, 0));
        wr(3'd2, 32'h8000_0000);
        rd(3'd0, v); chk("R8 source 0 disabled", v, st(0, 0, 0, 0, 0, 0));
        wr(3'd2, 32'h0);
        wr(3'd4, 32'h20);
        rd(3'd4, v); chk("R7 w1c clear", v, 32'h0);
        rd(3'd0, v); chk("R8 cascade drops", v, st(0, 0, 0, 0, 0, 0));
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd4; wdata = 32'h20; dma_set = 32'h20;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd0; wdata = '0; dma_set = '0;
        rd(3'd4, v); chk("R7 set wins same bit", v, 32'h20);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd4; wdata = 32'h20; dma_set = 32'h40;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd0; wdata = '0; dma_set = '0;
        rd(3'd4, v); chk("R7 clear one set other", v, 32'h40);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
    endtask

    task automatic t_promo;
        logic [31:0] v;
        wr(3'd3, 32'h109);
        per_req[9] = 1'b1; per_req[3] = 1'b1;
        rd(3'd0, v); chk("R6 promote to crit", v, st(1, 2, 0, 0, 1, 9));
        crit_req = 4'b0001;
        rd(3'd0, v); chk("R6 real crit beats alias", v, st(1, 0, 0, 0, 1, 9));
        crit_req = 4'b0;
        wr(3'd3, 32'h209);
        rd(3'd0, v); chk("R6 promote to main", v, st(0, 0, 1, 4, 1, 9));
        main_req = 16'h0004;
        rd(3'd0, v); chk("R6 main 2 beats alias", v, st(0, 0, 1, 2, 1, 9));
        main_req = 16'h0;
        wr(3'd2, 32'h0040_0000);
        rd(3'd0, v); chk("R6 promoted source disabled", v, st(0, 0, 0, 0, 1, 3));
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h309);
        rd(3'd0, v); chk("R6 mode 3 off", v, st(0, 0, 0, 0, 1, 3));
        per_req = '0;
        wr(3'd3, 32'h0);
    endtask

    task automatic t_all_tiers;
        logic [31:0] v;
        @(negedge clk);
        crit_req = 4'b1000; main_req = 16'h0001; per_req[1] = 1'b1;
        rd(3'd0, v); chk("R2 three tiers together", v, st(1, 3, 1, 0, 1, 1));
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R9 status write ignored", v, st(1, 3, 1, 0, 1, 1));
        crit_req = '0; main_req = '0; per_req = '0;
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R9 promotion readback", v, 32'h0000_031F);
        wr(3'd3, 32'h0);
        rd(3'd6, v); chk("R9 addr 6 zero", v, 32'h0);
        rd(3'd7, v); chk("R9 addr 7 zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_crit;
        t_main;
        t_per;
        t_dma;
        t_promo;
        t_all_tiers;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog got=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule